// File: doc/BRIEF.md
# Ultimately Periodic Fire-Enable Sequencer

This block tells a statically scheduled compute node in which base-clock cycles it may execute. The schedule is a binary word of two parts: a finite lead-in (which may be empty) that is played once, and a loop section that is then replayed for as long as the block runs. A 1 symbol makes the node execute in that cycle and a 0 symbol keeps it idle. Both parts are held as bit vectors with their own lengths. Software or a boot sequencer loads them through a write port while the schedule is stopped.

While the run input is high, the block consumes one symbol per cycle and presents it on `fire`. Each time a pass through the loop section completes, it reports how many fires that pass contained. The throughput of the node is that count divided by the loop length: for example 1/2 for a loop of `10` and 2/3 for a loop of `110`. Typical schedules are "one, then zero forever" (inject initial wire values once), "zero, then one forever" (start one cycle late), and "00 then 101 repeated".

Top module: `upw_fire_seq`

## Requirements
- R1: `fire` is high in a cycle exactly when `run` is high and the symbol at the current position of the word is 1. A 1 symbol means execute and a 0 symbol means idle.
- R2: After reset, `fire`, `loop_done` and `loop_fires` are 0. The stored schedule is an empty lead-in followed by a loop of length 1 whose single symbol is 1.
- R3: Symbol j of the lead-in is bit j of `cfg_lead_bits`, and symbol j of the loop is bit j of `cfg_loop_bits`. The lead-in symbols are played in the order 0 to length-1. The loop symbols 0 to length-1 follow and then repeat without end.
- R4: When the lead-in length is 0, the first running cycle plays loop symbol 0.
- R5: A cycle with `run` low consumes no symbol. When `run` returns high, play resumes at the symbol where it stopped.
- R6: A write (`cfg_we` high) is accepted only in a cycle where `run` is low. A write made while `run` is high changes neither the schedule nor the current position.
- R7: A write is rejected as a whole if its loop length is 0 or above 32, or if its lead-in length is above 32.
- R8: An accepted write takes effect from the next cycle and restarts play at the first symbol of the new word. It also clears `loop_fires` and drops any pending `loop_done`.
- R9: In the cycle after the cycle that consumed the last loop symbol, `loop_done` is high for one cycle. In that same cycle `loop_fires` shows the number of fires in that pass, and it holds that value until the next pass completes. Fires from lead-in symbols are not counted.
- R10: Both the lead-in and the loop may be as long as 32 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one symbol per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_lead_bits | input | 32 | Lead-in symbols, symbol j in bit j |
| cfg_lead_len | input | 6 | Lead-in length, 0 to 32 |
| cfg_loop_bits | input | 32 | Loop symbols, symbol j in bit j |
| cfg_loop_len | input | 6 | Loop length, 1 to 32 |
| run | input | 1 | Advance the schedule this cycle |
| fire | output | 1 | Execute enable for the node |
| loop_done | output | 1 | One-cycle pulse after each completed loop pass |
| loop_fires | output | 6 | Fires counted in the last completed loop pass |

## Verification
The bench checks each cycle against a reference word built from the requirements. It concentrates on the point where the lead-in hands over to the loop. A design that re-enters the lead-in, skips loop symbol 0 or wraps one symbol early shows a shifted fire pattern on `00` then `101` and on "one then zero forever". An empty lead-in and full 32-symbol parts catch off-by-one errors in the length compares. Pauses in the middle of a pass catch a pointer that drifts while stopped. Writes made while running, and writes with illegal lengths, catch a design that restarts or corrupts its schedule when it should not. The per-pass count is checked after a restart and after a pass that contains lead-in fires, which exposes stale or inflated totals.

// File: rtl/upw_pkg.sv
// Shared types for the ultimately periodic fire sequencer.
package upw_pkg;
    // Which part of the schedule word the pointer is in.
    typedef enum logic {
        PH_LEAD = 1'b0,
        PH_LOOP = 1'b1
    } upw_phase_e;
endpackage

// File: rtl/upw_cfg_bank.sv
// Holds the schedule word: lead-in bits and length, and loop bits and length.
// Assumes the writer presents a complete word in one cycle. A write is taken
// only while run is low and only when both lengths are legal.
module upw_cfg_bank #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               cfg_we,
    input  logic [MAX_LEN-1:0] cfg_lead_bits,
    input  logic [LEN_W-1:0]   cfg_lead_len,
    input  logic [MAX_LEN-1:0] cfg_loop_bits,
    input  logic [LEN_W-1:0]   cfg_loop_len,
    output logic [MAX_LEN-1:0] lead_bits,
    output logic [LEN_W-1:0]   lead_len,
    output logic [MAX_LEN-1:0] loop_bits,
    output logic [LEN_W-1:0]   loop_len,
    output logic               take
);
    logic legal;

    // Length legality of the word on the write port.
    always_comb begin
        legal = (cfg_loop_len != '0) &&
                (cfg_loop_len <= LEN_W'(MAX_LEN)) &&
                (cfg_lead_len <= LEN_W'(MAX_LEN));
    end

    // A write is accepted only while the schedule is stopped.
    assign take = cfg_we && !run && legal;

    // Schedule storage with its reset word: no lead-in, loop "1".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_bits <= '0;
            lead_len  <= '0;
            loop_bits <= MAX_LEN'(1);
            loop_len  <= LEN_W'(1);
        end else if (take) begin
            lead_bits <= cfg_lead_bits;
            lead_len  <= cfg_lead_len;
            loop_bits <= cfg_loop_bits;
            loop_len  <= cfg_loop_len;
        end
    end

    AST_CFG_LOCKED_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(loop_len) && $stable(lead_len) && $stable(loop_bits) && $stable(lead_bits))); // R6
    AST_LOOP_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_len != '0) && (loop_len <= LEN_W'(MAX_LEN)) && (lead_len <= LEN_W'(MAX_LEN))); // R7
endmodule

// File: rtl/upw_walker.sv
// Position pointer inside the schedule word. It walks the lead-in once and
// then circles the loop. Assumes MAX_LEN >= 2 and legal stored lengths.
// On restart it loads the start position of the word being written.
module upw_walker
    import upw_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             restart,
    input  logic [LEN_W-1:0] new_lead_len,
    input  logic [LEN_W-1:0] lead_len,
    input  logic [LEN_W-1:0] loop_len,
    output upw_phase_e       phase,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);
    logic at_lead_end;
    logic at_loop_end;

    // Detect the last symbol of the current part.
    always_comb begin
        at_lead_end = (LEN_W'(idx) == lead_len - LEN_W'(1));
        at_loop_end = (LEN_W'(idx) == loop_len - LEN_W'(1));
    end

    assign wrap = advance && (phase == PH_LOOP) && at_loop_end;

    // Step the pointer one symbol per running cycle; a restart reloads the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOOP;
            idx   <= '0;
        end else if (restart) begin
            phase <= (new_lead_len != '0) ? PH_LEAD : PH_LOOP;
            idx   <= '0;
        end else if (advance) begin
            if (phase == PH_LEAD) begin
                if (at_lead_end) begin
                    phase <= PH_LOOP;
                    idx   <= '0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end else begin
                idx <= at_loop_end ? '0 : idx + IDX_W'(1);
            end
        end
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> ($stable(idx) && $stable(phase))); // R5
    AST_LOOP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOOP) |-> (LEN_W'(idx) < loop_len)); // R3
    AST_LEAD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LEAD) |-> (LEN_W'(idx) < lead_len)); // R10
endmodule

// File: rtl/upw_act_count.sv
// Counts the fires of loop symbols during one pass. At each wrap it
// publishes the total and pulses done. Assumes wrap and restart never
// occur in the same cycle, because restart needs run low.
module upw_act_count #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic             wrap,
    input  logic             loop_hit,
    input  logic [LEN_W-1:0] loop_len,
    output logic [LEN_W-1:0] loop_fires,
    output logic             loop_done
);
    logic [LEN_W-1:0] tally;

    // Accumulate the pass total and publish it when the pass closes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tally      <= '0;
            loop_fires <= '0;
            loop_done  <= 1'b0;
        end else begin
            loop_done <= 1'b0;
            if (wrap) begin
                loop_fires <= tally + LEN_W'(loop_hit);
                tally      <= '0;
                loop_done  <= 1'b1;
            end else if (advance) begin
                tally <= tally + LEN_W'(loop_hit);
            end
        end
    end

    AST_FIRES_WITHIN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        loop_fires <= loop_len); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done && (loop_len != LEN_W'(1)) |=> !loop_done); // R9
endmodule

// File: rtl/upw_fire_seq.sv
// Top of the ultimately periodic fire sequencer. It plays a lead-in word
// once and then a loop word forever, one symbol per running cycle, and
// drives the node's execute enable. Assumes MAX_LEN >= 2.
module upw_fire_seq
    import upw_pkg::*;
#(
    parameter int  MAX_LEN = 32,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [MAX_LEN-1:0] cfg_lead_bits,
    input  logic [LEN_W-1:0]   cfg_lead_len,
    input  logic [MAX_LEN-1:0] cfg_loop_bits,
    input  logic [LEN_W-1:0]   cfg_loop_len,
    input  logic               run,
    output logic               fire,
    output logic               loop_done,
    output logic [LEN_W-1:0]   loop_fires
);
    logic [MAX_LEN-1:0] lead_bits;
    logic [LEN_W-1:0]   lead_len;
    logic [MAX_LEN-1:0] loop_bits;
    logic [LEN_W-1:0]   loop_len;
    logic               take;
    upw_phase_e         phase;
    logic [IDX_W-1:0]   idx;
    logic               wrap;
    logic               sym;

    upw_cfg_bank #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
        .cfg_lead_bits(cfg_lead_bits), .cfg_lead_len(cfg_lead_len),
        .cfg_loop_bits(cfg_loop_bits), .cfg_loop_len(cfg_loop_len),
        .lead_bits(lead_bits), .lead_len(lead_len),
        .loop_bits(loop_bits), .loop_len(loop_len), .take(take)
    );

    upw_walker #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_walk (
        .clk(clk), .rst_n(rst_n), .advance(run), .restart(take),
        .new_lead_len(cfg_lead_len), .lead_len(lead_len), .loop_len(loop_len),
        .phase(phase), .idx(idx), .wrap(wrap)
    );

    // Select the symbol under the pointer.
    always_comb begin
        sym = (phase == PH_LEAD) ? lead_bits[idx] : loop_bits[idx];
    end

    assign fire = run && sym;

    upw_act_count #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .restart(take), .advance(run), .wrap(wrap),
        .loop_hit(fire && (phase == PH_LOOP)), .loop_len(loop_len),
        .loop_fires(loop_fires), .loop_done(loop_done)
    );

    AST_DONE_AT_LOOP_START: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> (phase == PH_LOOP && idx == '0)); // R9
    AST_EMPTY_LEAD_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_len == '0) |-> (phase == PH_LOOP)); // R4
    AST_RESTART_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (idx == '0)); // R8
endmodule

// File: tb/test_upw_fire_seq.sv
// Scoreboard bench: the driver pushes the expected outputs of each cycle,
// and the monitor pops them and compares them with the sampled outputs.
module test_upw_fire_seq;
    localparam int ML = 32;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [ML-1:0] cfg_lead_bits = '0;
    logic [LW-1:0] cfg_lead_len = '0;
    logic [ML-1:0] cfg_loop_bits = '0;
    logic [LW-1:0] cfg_loop_len = '0;
    logic          run = 1'b0;
    logic          fire;
    logic          loop_done;
    logic [LW-1:0] loop_fires;

    upw_fire_seq #(.MAX_LEN(ML)) i_upw_fire_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_lead_bits(cfg_lead_bits), .cfg_lead_len(cfg_lead_len),
        .cfg_loop_bits(cfg_loop_bits), .cfg_loop_len(cfg_loop_len),
        .run(run), .fire(fire), .loop_done(loop_done), .loop_fires(loop_fires)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic        f;
        logic        d;
        logic [LW-1:0] o;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;

    // Reference schedule and position, derived from the requirements.
    logic [ML-1:0] m_lbits = '0;
    int            m_llen = 0;
    logic [ML-1:0] m_pbits = 32'h1;
    int            m_plen = 1;
    int            m_k = 0;
    logic          m_pend = 1'b0;
    logic [LW-1:0] m_ones = '0;

    function automatic logic word_bit(int k);
        if (k < m_llen) return m_lbits[k];
        return m_pbits[(k - m_llen) % m_plen];
    endfunction

    function automatic logic [LW-1:0] loop_ones();
        int c = 0;
        for (int j = 0; j < m_plen; j++) c += int'(m_pbits[j]);
        return LW'(c);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected outputs of this cycle, followed by the model step at the edge.
    task automatic push_and_step(logic r, string tag);
        exp_t e;
        e.f = r && word_bit(m_k);
        e.d = m_pend;
        e.o = m_ones;
        e.tag = tag;
        exp_q.push_back(e);
        m_pend = 1'b0;
        if (r) begin
            if (m_k >= m_llen && ((m_k - m_llen) % m_plen) == m_plen - 1) begin
                m_pend = 1'b1;
                m_ones = loop_ones();
            end
            m_k++;
        end
    endtask

    task automatic cycles(int n, logic r, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            run = r;
            cfg_we = 1'b0;
            push_and_step(r, tag);
        end
    endtask

    // One write cycle; r selects whether run is high while writing.
    task automatic write_cfg(logic r, logic [ML-1:0] lb, int ll,
                             logic [ML-1:0] pb, int pl, string tag);
        bit ok;
        @(negedge clk);
        run = r;
        cfg_we = 1'b1;
        cfg_lead_bits = lb;
        cfg_lead_len = LW'(ll);
        cfg_loop_bits = pb;
        cfg_loop_len = LW'(pl);
        ok = !r && pl >= 1 && pl <= ML && ll <= ML;
        push_and_step(r, tag);
        if (ok) begin
            m_lbits = lb; m_llen = ll; m_pbits = pb; m_plen = pl;
            m_k = 0; m_pend = 1'b0; m_ones = '0;
        end
    endtask

    // Monitor: pop one expected item per cycle and compare after settling.
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "fire", int'(fire), int'(e.f));
            check(e.tag, "loop_done", int'(loop_done), int'(e.d));
            check(e.tag, "loop_fires", int'(loop_fires), int'(e.o));
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R2", "reset fire", int'(fire), 0);
        check("R2", "reset loop_done", int'(loop_done), 0);
        check("R2", "reset loop_fires", int'(loop_fires), 0);
        // R2: the reset word fires every cycle, with one fire per pass.
        cycles(4, 1'b1, "R2");
        // R1 R8: one, then zero forever.
        write_cfg(1'b0, 32'h1, 1, 32'h0, 1, "R8");
        cycles(6, 1'b1, "R1");
        // R4: zero, then one forever; with an empty lead-in, loop "10".
        write_cfg(1'b0, 32'h0, 1, 32'h1, 1, "R3");
        cycles(5, 1'b1, "R3");
        write_cfg(1'b0, 32'h0, 0, 32'h1, 2, "R4");
        cycles(7, 1'b1, "R4");
        // R3: lead-in 00, then 101 repeated.
        write_cfg(1'b0, 32'h0, 2, 32'h5, 3, "R3");
        cycles(11, 1'b1, "R3");
        // R5: pause in the middle of a pass and resume.
        cycles(3, 1'b0, "R5");
        cycles(7, 1'b1, "R5");
        // Loop 110, lead-in "1" (a lead-in fire is not counted).
        write_cfg(1'b0, 32'h1, 1, 32'h3, 3, "R9");
        cycles(10, 1'b1, "R9");
        // R6: a write while running is ignored.
        write_cfg(1'b1, 32'h0, 0, 32'h0, 4, "R6");
        cycles(6, 1'b1, "R6");
        // R7: illegal lengths are rejected; no restart follows.
        write_cfg(1'b0, 32'h0, 0, 32'h0, 0, "R7");
        cycles(4, 1'b1, "R7");
        write_cfg(1'b0, 32'h0, 0, 32'hFFFF_FFFF, 33, "R7");
        write_cfg(1'b0, 32'h0, 40, 32'h0, 2, "R7");
        cycles(4, 1'b1, "R7");
        // R10: both parts at the maximum length of 32.
        write_cfg(1'b0, 32'hA000_0003, 32, 32'h8000_0011, 32, "R10");
        cycles(100, 1'b1, "R10");
        cycles(2, 1'b0, "R10");
        cycles(3, 1'b1, "R10");
        repeat (2) @(negedge clk);
        #4;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule